// File: doc/BRIEF.md
# PCI configuration address translator

This block sits on a host bridge between the processor-side bus and the engine that runs PCI configuration cycles. The host sees two windows: an address window that holds a 32-bit configuration address register, and a data window through which configuration reads and writes of 1, 2 or 4 bytes are made. On every data-window access the block turns the held address, together with the low three offset bits of the data window, into a standard linear configuration address (device, function and register fields). It then runs one request/response exchange with the configuration engine and returns the read data to the host.

Flag bits in the held address choose how it is translated. Bit 31 selects a pass-through form. Otherwise bit 0 selects a bridged (type-1) form. Otherwise the access is type-0: the device number is taken from a one-hot select bit in bits 31:11, by finding the lowest bit that is set. A build parameter turns on big-endian data handling, which reverses bytes according to the access length in both directions. The host decodes the two 4 KiB windows and drives a window select together with the low offset bits.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset `host_rdy` is 1, `host_ack` and `eng_req` are 0, and the address register reads as 0.
- R2: An address-window access (`host_sel`=0) makes no engine request and is acknowledged one cycle after it is accepted. A write loads `host_wdata` unswapped into the address register. A read returns the register's current value.
- R3: If bit 31 of the address register is set, `eng_addr` is the register value with bits 1:0 replaced by `host_off[1:0]`.
- R4: If bit 31 is clear and bit 0 is set, `eng_addr` is the register value with bits 2:0 replaced by `host_off[2:0]`.
- R5: If bits 31 and 0 are both clear, `eng_addr` is built as follows. Bits 15:11 hold the device number, which is the index, counted from bit 11, of the lowest set bit in register bits 31:11. Bits 10:3 are copied from the register. Bits 2:0 are `host_off[2:0]`. Bits 31:16 are 0.
- R6: A type-0 data access with register bits 31:11 all clear makes no engine request. It is acknowledged one cycle after acceptance with `host_err`=1. A read returns 0xFFFFFFFF. A write is dropped, and later reads of the address register show it unchanged.
- R7: With big-endian mode on, `eng_wdata` is `host_wdata` with its bytes swapped by length. Length 1 leaves it unchanged. Length 2 swaps bytes 0 and 1 and keeps bytes 3:2. Length 4 reverses all four bytes.
- R8: With big-endian mode on, `host_rdata` of a data read is `eng_rdata`, swapped by length in the same way as in R7.
- R9: Only one access is outstanding at a time. `host_rdy` is 0 from acceptance until completion. `eng_req` and `eng_addr` hold steady until `eng_ack`. `host_ack` pulses in the cycle after `eng_ack` is sampled.
- R10: `eng_we` and `eng_len` equal the `host_we` and `host_len` of the accepted access. Lengths are encoded 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_rdy | output | 1 | Block idle; request accepted when both are high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address window, 1 = data window |
| host_off | input | 3 | Low offset bits within the data window |
| host_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | With host_ack: type-0 access had no device select bit |
| host_rdata | output | 32 | Read data, valid with host_ack |
| eng_req | output | 1 | Configuration request to the engine |
| eng_we | output | 1 | Request is a write |
| eng_addr | output | 32 | Translated configuration address |
| eng_len | output | 3 | Request length in bytes |
| eng_wdata | output | 32 | Write data, already swapped |
| eng_ack | input | 1 | Engine completion |
| eng_rdata | input | 32 | Engine read data, valid with eng_ack |

## Verification
The assertions assume that the host uses only lengths 1, 2 and 4 on data-window accesses. They also assume that the engine raises `eng_ack` only while `eng_req` is high. The scoreboard's driver waits for `host_rdy` and for the acknowledge of each access before it issues the next one. The engine stub answers every request exactly once, after one to three cycles, and returns data derived from the address. Together these keep the stimulus within those assumptions, while the stub's varied delays exercise the hold-until-ack rule.

// File: rtl/cax_pkg.sv
// Shared constants, types and the length-driven byte swap for the
// configuration address translator. Assumes a 32-bit data path.
package cax_pkg;
    localparam int CAX_AW      = 32;  // configuration address width
    localparam int CAX_DW      = 32;  // data width
    localparam int CAX_DEV_LSB = 11;  // lowest device-select bit
    localparam int CAX_OFF_W   = 3;   // data-window offset bits used
    localparam int CAX_LEN_W   = 3;

    localparam logic [CAX_LEN_W-1:0] LEN_1 = 3'd1;
    localparam logic [CAX_LEN_W-1:0] LEN_2 = 3'd2;
    localparam logic [CAX_LEN_W-1:0] LEN_4 = 3'd4;

    typedef enum logic [1:0] {MODE_PASS, MODE_T1, MODE_T0} cax_mode_t;
    typedef enum logic [0:0] {ST_IDLE, ST_WAIT} cax_st_t;

    // Swap bytes by access length: 2 swaps the low pair, 4 reverses all.
    function automatic logic [CAX_DW-1:0] cax_swap_f(input logic [CAX_DW-1:0] d,
                                                     input logic [CAX_LEN_W-1:0] len);
        case (len)
            LEN_1:   return d;
            LEN_2:   return {d[31:16], d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction
endpackage

// File: rtl/cax_xlate.sv
// Combinational translation of the held configuration address and the
// data-window offset into a linear configuration address.
// Assumes the device-select field runs from DEV_LSB to the top bit.
module cax_xlate
    import cax_pkg::*;
#(
    parameter int AW      = CAX_AW,
    parameter int DEV_LSB = CAX_DEV_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        lat,
    input  logic [CAX_OFF_W-1:0] off,
    output logic [AW-1:0]        addr,
    output logic                 invalid
);
    localparam int NSEL  = AW - DEV_LSB;
    localparam int DEV_W = $clog2(NSEL);

    logic [NSEL-1:0]  sel_bits;
    logic [DEV_W-1:0] dev;
    logic             hit;
    cax_mode_t        mode;

    assign sel_bits = lat[AW-1:DEV_LSB];

    // Priority search for the lowest set select bit.
    always_comb begin
        dev = '0;
        hit = 1'b0;
        for (int i = NSEL - 1; i >= 0; i--) begin
            if (sel_bits[i]) begin
                dev = DEV_W'(i);
                hit = 1'b1;
            end
        end
    end

    // Mode choice: top flag first, then the bridged flag.
    always_comb begin
        if (lat[AW-1])  mode = MODE_PASS;
        else if (lat[0]) mode = MODE_T1;
        else             mode = MODE_T0;
    end

    // Assemble the output address for the chosen mode.
    always_comb begin
        addr = '0;
        case (mode)
            MODE_PASS: addr = {lat[AW-1:2], off[1:0]};
            MODE_T1:   addr = {lat[AW-1:3], off};
            default: begin
                addr[DEV_LSB +: DEV_W] = dev;
                addr[DEV_LSB-1:3]      = lat[DEV_LSB-1:3];
                addr[2:0]              = off;
            end
        endcase
    end

    assign invalid = (mode == MODE_T0) && !hit;

    AST_DEV_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_T0 && hit) |->
            (sel_bits[dev] && ((sel_bits & ((NSEL'(1) << dev) - NSEL'(1))) == '0))); // R5
endmodule

// File: rtl/cax_bswap.sv
// Optional byte swap by access length. Assumes len is 1, 2 or 4;
// when BIG_ENDIAN is 0 the data passes unchanged.
module cax_bswap
    import cax_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CAX_LEN_W-1:0] len,
    input  logic [CAX_DW-1:0]    din,
    output logic [CAX_DW-1:0]    dout
);
    // Pick the swapping or the straight variant at build time.
    generate
        if (BIG_ENDIAN) begin : g_swap
            assign dout = cax_swap_f(din, len);
        end else begin : g_flat
            assign dout = din;
        end
    endgenerate

    AST_SWAP_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dout) == $countones(din)); // R7 R8
    AST_LEN1_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (len == LEN_1) |-> (dout == din)); // R7
endmodule

// File: rtl/cax_ctrl.sv
// Holds the address register and runs one engine handshake per data
// access. Assumes the engine raises eng_ack only while eng_req is high.
module cax_ctrl
    import cax_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic                 host_sel,
    input  logic [CAX_LEN_W-1:0] host_len,
    input  logic [CAX_DW-1:0]    host_wdata,
    input  logic [CAX_DW-1:0]    wdata_sw,
    input  logic [CAX_AW-1:0]    x_addr,
    input  logic                 x_invalid,
    input  logic                 eng_ack,
    input  logic [CAX_DW-1:0]    rdata_sw,
    output logic                 host_rdy,
    output logic                 host_ack,
    output logic                 host_err,
    output logic [CAX_DW-1:0]    host_rdata,
    output logic [CAX_AW-1:0]    lat,
    output logic                 eng_req,
    output logic                 eng_we,
    output logic [CAX_AW-1:0]    eng_addr,
    output logic [CAX_LEN_W-1:0] eng_len,
    output logic [CAX_DW-1:0]    eng_wdata
);
    cax_st_t st;
    logic    acc;

    assign host_rdy = (st == ST_IDLE);
    assign acc      = host_req && host_rdy;

    // Accept host accesses, run the engine exchange, return the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            lat        <= '0;
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
            eng_req    <= 1'b0;
            eng_we     <= 1'b0;
            eng_addr   <= '0;
            eng_len    <= '0;
            eng_wdata  <= '0;
        end else begin
            host_ack <= 1'b0;
            host_err <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (acc && !host_sel) begin
                        if (host_we) lat <= host_wdata;
                        host_rdata <= lat;
                        host_ack   <= 1'b1;
                    end else if (acc && x_invalid) begin
                        host_rdata <= '1;
                        host_ack   <= 1'b1;
                        host_err   <= 1'b1;
                    end else if (acc) begin
                        eng_req   <= 1'b1;
                        eng_we    <= host_we;
                        eng_addr  <= x_addr;
                        eng_len   <= host_len;
                        eng_wdata <= wdata_sw;
                        st        <= ST_WAIT;
                    end
                end
                default: begin
                    if (eng_ack) begin
                        eng_req    <= 1'b0;
                        host_rdata <= rdata_sw;
                        host_ack   <= 1'b1;
                        st         <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_addr) && $stable(eng_wdata))); // R9
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack) |=> (host_ack && !eng_req)); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !host_rdy); // R9
    AST_INVALID_NO_ENG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_sel && x_invalid) |=> (host_ack && host_err && !eng_req)); // R6
    AST_ADDR_WIN_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !host_sel) |=> (host_ack && !eng_req && !host_err)); // R2
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_sel) |-> (host_len == LEN_1 || host_len == LEN_2 || host_len == LEN_4)); // R10
endmodule

// File: rtl/cfg_addr_xlate.sv
// Top of the configuration address translator: address register,
// translation, byte swaps and the engine handshake.
// Assumes the host decodes both windows and drives host_sel.
module cfg_addr_xlate
    import cax_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    output logic                 host_rdy,
    input  logic                 host_we,
    input  logic                 host_sel,
    input  logic [CAX_OFF_W-1:0] host_off,
    input  logic [CAX_LEN_W-1:0] host_len,
    input  logic [CAX_DW-1:0]    host_wdata,
    output logic                 host_ack,
    output logic                 host_err,
    output logic [CAX_DW-1:0]    host_rdata,
    output logic                 eng_req,
    output logic                 eng_we,
    output logic [CAX_AW-1:0]    eng_addr,
    output logic [CAX_LEN_W-1:0] eng_len,
    output logic [CAX_DW-1:0]    eng_wdata,
    input  logic                 eng_ack,
    input  logic [CAX_DW-1:0]    eng_rdata
);
    logic [CAX_AW-1:0] lat;
    logic [CAX_AW-1:0] x_addr;
    logic              x_invalid;
    logic [CAX_DW-1:0] wdata_sw;
    logic [CAX_DW-1:0] rdata_sw;

    cax_xlate u_xlate (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat     (lat),
        .off     (host_off),
        .addr    (x_addr),
        .invalid (x_invalid)
    );

    cax_bswap #(.BIG_ENDIAN(BIG_ENDIAN)) u_wswap (
        .clk   (clk),
        .rst_n (rst_n),
        .len   (host_len),
        .din   (host_wdata),
        .dout  (wdata_sw)
    );

    cax_bswap #(.BIG_ENDIAN(BIG_ENDIAN)) u_rswap (
        .clk   (clk),
        .rst_n (rst_n),
        .len   (eng_len),
        .din   (eng_rdata),
        .dout  (rdata_sw)
    );

    cax_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_len   (host_len),
        .host_wdata (host_wdata),
        .wdata_sw   (wdata_sw),
        .x_addr     (x_addr),
        .x_invalid  (x_invalid),
        .eng_ack    (eng_ack),
        .rdata_sw   (rdata_sw),
        .host_rdy   (host_rdy),
        .host_ack   (host_ack),
        .host_err   (host_err),
        .host_rdata (host_rdata),
        .lat        (lat),
        .eng_req    (eng_req),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_len    (eng_len),
        .eng_wdata  (eng_wdata)
    );
endmodule

// File: tb/sim_cfg_addr_xlate.sv
// Scoreboard bench: the driver queues expectations, an engine stub checks
// each request and answers it, a monitor checks each host completion.
module sim_cfg_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [2:0]  host_off = '0, host_len = 3'd4;
    logic [31:0] host_wdata = '0;
    logic        host_rdy, host_ack, host_err;
    logic [31:0] host_rdata;
    logic        eng_req, eng_we;
    logic [31:0] eng_addr, eng_wdata;
    logic [2:0]  eng_len;
    logic        eng_ack = 1'b0;
    logic [31:0] eng_rdata = '0;

    always #4 clk = ~clk;

    cfg_addr_xlate #(.BIG_ENDIAN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rdy(host_rdy),
        .host_we(host_we), .host_sel(host_sel), .host_off(host_off),
        .host_len(host_len), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_err(host_err), .host_rdata(host_rdata), .eng_req(eng_req),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_len(eng_len),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    typedef struct {
        bit          we;
        bit          exp_eng;
        bit          chk_rd;
        bit          eerr;
        logic [2:0]  len;
        logic [31:0] eaddr;
        logic [31:0] ewdata;
        logic [31:0] erdata;
        string       tag;
    } item_t;

    item_t       q[$];
    int          n_chk = 0, n_fail = 0, done_cnt = 0, wait_cnt = 0, n_req = 0;
    bit          eng_seen = 1'b0, stub_busy = 1'b0;
    logic [31:0] cap_addr, blat = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sw(input logic [31:0] d, input logic [2:0] len);
        if (len == 3'd1) return d;
        if (len == 3'd2) return {d[31:16], d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] xl(input logic [31:0] l, input logic [2:0] o);
        int dev = 0;
        if (l[31]) return {l[31:2], o[1:0]};
        if (l[0])  return {l[31:3], o};
        for (int i = 31; i >= 11; i--) if (l[i]) dev = i - 11;
        return (dev * 2048) + ({24'd0, l[10:3]} * 8) + {29'd0, o};
    endfunction

    function automatic logic [31:0] resp(input logic [31:0] a);
        return a ^ 32'h5A3C_0F96;
    endfunction

    // Engine stub: checks each new request against the queue head, answers later.
    always @(negedge clk) begin
        if (eng_ack) begin
            eng_ack   = 1'b0;
            stub_busy = 1'b0;
        end else if (rst_n && eng_req && !stub_busy) begin
            stub_busy = 1'b1;
            eng_seen  = 1'b1;
            cap_addr  = eng_addr;
            n_req++;
            wait_cnt  = 1 + (n_req % 3);
            if (q.size() == 0) begin
                check(1'b0, "R9", "request with nothing queued", 32'd1, 32'd0);
            end else begin
                check(q[0].exp_eng, q[0].tag, "unexpected engine request", 32'd1, 32'd0);
                check(eng_addr == q[0].eaddr, q[0].tag, "eng_addr", eng_addr, q[0].eaddr);
                check(eng_we == q[0].we, "R10", "eng_we", {31'd0, eng_we}, {31'd0, q[0].we});
                check(eng_len == q[0].len, "R10", "eng_len", {29'd0, eng_len}, {29'd0, q[0].len});
                if (q[0].we)
                    check(eng_wdata == q[0].ewdata, "R7", "eng_wdata", eng_wdata, q[0].ewdata);
                check(!host_rdy, "R9", "host_rdy while busy", {31'd0, host_rdy}, 32'd0);
            end
        end else if (stub_busy && eng_req) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
                check(eng_addr == cap_addr, "R9", "eng_addr held", eng_addr, cap_addr);
                eng_ack   = 1'b1;
                eng_rdata = resp(eng_addr);
            end
        end
    end

    // Monitor: pops one expectation per host completion and compares.
    always @(negedge clk) begin
        if (rst_n && host_ack) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", "ack with nothing queued", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = q.pop_front();
                if (it.chk_rd)
                    check(host_rdata == it.erdata, it.tag, "host_rdata", host_rdata, it.erdata);
                check(host_err == it.eerr, it.tag, "host_err", {31'd0, host_err}, {31'd0, it.eerr});
                check(eng_seen == it.exp_eng, it.tag, "engine used", {31'd0, eng_seen}, {31'd0, it.exp_eng});
            end
            eng_seen = 1'b0;
            done_cnt++;
        end
    end

    // Driver: queue the expectation, issue one access, wait for completion.
    task automatic access(input bit sel, input bit we, input logic [2:0] off,
                          input logic [2:0] len, input logic [31:0] wd, input string tag);
        item_t it;
        int    tgt;
        logic  inv;
        it.we = we; it.len = len; it.tag = tag; it.ewdata = sw(wd, len);
        inv = !blat[31] && !blat[0] && (blat[31:11] == '0);
        if (!sel) begin
            it.exp_eng = 1'b0; it.chk_rd = !we; it.eerr = 1'b0;
            it.erdata = blat; it.eaddr = '0;
            if (we) blat = wd;
        end else if (inv) begin
            it.exp_eng = 1'b0; it.chk_rd = !we; it.eerr = 1'b1;
            it.erdata = 32'hFFFF_FFFF; it.eaddr = '0;
        end else begin
            it.exp_eng = 1'b1; it.chk_rd = !we; it.eerr = 1'b0;
            it.eaddr = xl(blat, off);
            it.erdata = sw(resp(it.eaddr), len);
        end
        q.push_back(it);
        tgt = done_cnt + 1;
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
        host_req = 1'b1; host_sel = sel; host_we = we;
        host_off = off; host_len = len; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (done_cnt != tgt) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_rdy == 1'b1, "R1", "host_rdy after reset", {31'd0, host_rdy}, 32'd1);
        check(host_ack == 1'b0, "R1", "host_ack after reset", {31'd0, host_ack}, 32'd0);
        check(eng_req == 1'b0, "R1", "eng_req after reset", {31'd0, eng_req}, 32'd0);
        access(1'b0, 1'b0, 3'd0, 3'd4, 32'd0, "R1");

        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h8000_1234, "R2");
        access(1'b0, 1'b0, 3'd0, 3'd4, 32'd0, "R2");
        access(1'b1, 1'b0, 3'd6, 3'd4, 32'd0, "R3 R8");
        access(1'b1, 1'b1, 3'd1, 3'd1, 32'h1122_3344, "R3 R7");

        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h0012_3405, "R2");
        access(1'b1, 1'b1, 3'd3, 3'd2, 32'hA1B2_C3D4, "R4 R7");
        access(1'b1, 1'b0, 3'd7, 3'd2, 32'd0, "R4 R8");

        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h0028_05C8, "R2");
        access(1'b1, 1'b0, 3'd7, 3'd1, 32'd0, "R5 R8");
        access(1'b1, 1'b1, 3'd0, 3'd4, 32'h0102_0304, "R5 R7");
        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h4000_0300, "R2");
        access(1'b1, 1'b1, 3'd4, 3'd4, 32'hDEAD_BEEF, "R5");
        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h0000_0800, "R2");
        access(1'b1, 1'b0, 3'd2, 3'd4, 32'd0, "R5");

        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h0000_07F8, "R2");
        access(1'b1, 1'b0, 3'd5, 3'd4, 32'd0, "R6");
        access(1'b1, 1'b1, 3'd5, 3'd4, 32'hCAFE_F00D, "R6");
        access(1'b0, 1'b0, 3'd0, 3'd4, 32'd0, "R6");
        access(1'b0, 1'b1, 3'd0, 3'd4, 32'h0100_0000, "R2");
        access(1'b1, 1'b0, 3'd0, 3'd2, 32'd0, "R5 R9");

        check(q.size() == 0, "R9", "queue drained", q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule